// File: doc/BRIEF.md
# Soft-Ramped Sample Attenuator with Soft Mute

This block is a single-channel digital volume stage that sits in front of a modulator. Signed samples arrive on a valid/ready stream and leave, scaled, on a second valid/ready stream. An 8-bit level code selects the target gain. The code runs from full scale down to mute in half-decibel steps. The applied gain never jumps to the new code. An internal fine level counter walks one step per accepted sample toward the target. A complete sweep from full scale to mute passes through 7425 fine levels.

A separate soft-mute control drives an independent counter. This counter ramps a second gain factor to zero while the control is held, and back to unity once it is released. Releasing the control partway through a ramp reverses the ramp at once. The product of the two gains scales each sample. The result is rounded and saturated to the sample width.

A power-down input restores the level code and both ramps to their full-scale state. A soft-reset input pins the fine level at full scale but keeps the programmed code, so the gain fades back down to it once soft reset is released. The output stage holds a single result register. A new sample is accepted when that register is empty or is being drained in the same cycle.

Top module: `soft_atten`

## Requirements
- R1: The fine target for code c is floor(c*LVL_MAX/255). Code 8'hFF targets LVL_MAX (unity). Code 8'h00 targets level 0, which gives a gain of exactly 0, so every output is 0.
- R2: The fine level changes only on an accepted sample (in_valid and in_ready high at a clock edge). Each accepted sample moves it by exactly one toward the target, and it stays put when already at the target. Going from 8'hFF to 8'h00 takes LVL_MAX accepted samples.
- R3: The soft-mute counter m (reset value MUTE_LEN) drops by one on each accepted sample while smute is high, and stops at 0. It rises by one on each accepted sample while smute is low, and stops at MUTE_LEN. A release in mid-ramp reverses the direction on the next accepted sample.
- R4: Attenuator gain for fine level L is as follows. With k = LVL_MAX-L, s = k/SEG and f = k%SEG (integer division), ga = (65536 - f*32768/SEG) >> s. ga is 0 when L = 0 or s > 16. The mute gain is gm = m*65536/MUTE_LEN.
- R5: Each output equals sat((x*g + 32768) >>> 16), where g = (ga*gm) >> 16 and sat clamps to the signed DW-bit range. The gains used are those held when the sample is accepted, before that sample's ramp step.
- R6: While pwr_dn is high, the code returns to 8'hFF, the fine level to LVL_MAX and m to MUTE_LEN. in_ready is low, any held output is dropped, and writes to att_code are ignored.
- R7: While soft_rst is high, the fine level is forced to LVL_MAX and the programmed code is kept. After release, the level ramps toward that code by the R2 rule.
- R8: in_ready is high exactly when pwr_dn is low and the output register is empty or out_ready is high. A held output keeps out_valid and out_data stable until it is taken.
- R9: The two ramps are independent. Changing the code never alters m, and toggling smute never alters the fine level or the code.
- R10: After rst_n is asserted, out_valid is 0, in_ready is 1, the code is 8'hFF and both ramps sit at unity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down, restores defaults while high |
| soft_rst | input | 1 | Soft reset, pins fine level at full scale |
| att_wr | input | 1 | Write strobe for att_code |
| att_code | input | 8 | Attenuation code, 8'hFF unity, 8'h00 mute |
| smute | input | 1 | Soft-mute request |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 24 | Signed scaled output sample |

## Verification
The bench keeps the default LVL_MAX of 7424 and SEG of 350, so the full-length fine sweep in both directions is exercised sample by sample. MUTE_LEN is reduced to 64. With that value a complete mute and unmute fits in a few dozen samples, and mid-ramp cancels land at many different counter positions during the random phase. Back-pressure is applied at random throughout. Each stalled cycle therefore also probes that the ramps do not advance without an accepted sample.

// File: rtl/att_pkg.sv
package att_pkg;
  localparam int GAIN_W = 17;
  localparam logic [31:0] UNITY = 32'd65536;

  // Gain of a fine level: linear interpolation inside each halving segment.
  function automatic logic [GAIN_W-1:0] lvl_gain(input logic [31:0] lvl,
                                                 input logic [31:0] lmax,
                                                 input logic [31:0] seg);
    logic [31:0] k, sh, fr, base;
    k    = lmax - lvl;
    sh   = k / seg;
    fr   = k % seg;
    base = UNITY - (fr * 32'd32768) / seg;
    base = base >> sh[4:0];
    if (lvl == 32'd0 || sh > 32'd16) return '0;
    return base[GAIN_W-1:0];
  endfunction
endpackage

// File: rtl/att_level_ramp.sv
module att_level_ramp #(
  parameter int CW      = 8,
  parameter int LVL_MAX = 7424,
  parameter int SEG     = 350,
  localparam int LW       = $clog2(LVL_MAX + 1),
  localparam int CODE_MAX = (1 << CW) - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pwr_dn,
  input  logic                       soft_rst,
  input  logic                       att_wr,
  input  logic [CW-1:0]              att_code,
  input  logic                       step,
  output logic [LW-1:0]              lvl,
  output logic [att_pkg::GAIN_W-1:0] gain
);
  logic [CW-1:0] code_q;
  logic [LW-1:0] lvl_q;
  logic [31:0]   tgt_full;
  logic [LW-1:0] tgt;

  always_comb begin
    tgt_full = (32'(code_q) * 32'(LVL_MAX)) / 32'(CODE_MAX);
    tgt      = tgt_full[LW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CW'(CODE_MAX);
      lvl_q  <= LW'(LVL_MAX);
    end else if (pwr_dn) begin
      code_q <= CW'(CODE_MAX);
      lvl_q  <= LW'(LVL_MAX);
    end else begin
      if (att_wr) code_q <= att_code;
      if (soft_rst)
        lvl_q <= LW'(LVL_MAX);
      else if (step) begin
        if (lvl_q < tgt)      lvl_q <= lvl_q + 1'b1;
        else if (lvl_q > tgt) lvl_q <= lvl_q - 1'b1;
      end
    end
  end

  assign lvl  = lvl_q;
  assign gain = att_pkg::lvl_gain(32'(lvl_q), 32'(LVL_MAX), 32'(SEG));
endmodule

// File: rtl/mute_ramp.sv
module mute_ramp #(
  parameter int MUTE_LEN = 1024,
  localparam int MW = $clog2(MUTE_LEN + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pwr_dn,
  input  logic                       smute,
  input  logic                       step,
  output logic [MW-1:0]              mlev,
  output logic [att_pkg::GAIN_W-1:0] gain
);
  logic [MW-1:0] m_q;
  logic [47:0]   scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      m_q <= MW'(MUTE_LEN);
    else if (pwr_dn)
      m_q <= MW'(MUTE_LEN);
    else if (step) begin
      if (smute) begin
        if (m_q != '0) m_q <= m_q - 1'b1;
      end else begin
        if (m_q != MW'(MUTE_LEN)) m_q <= m_q + 1'b1;
      end
    end
  end

  always_comb scaled = (48'(m_q) << 16) / 48'(MUTE_LEN);

  assign mlev = m_q;
  assign gain = scaled[att_pkg::GAIN_W-1:0];
endmodule

// File: rtl/gain_scaler.sv
module gain_scaler #(
  parameter int DW = 24,
  localparam int GW = att_pkg::GAIN_W,
  localparam int PW = DW + GW + 1
) (
  input  logic [DW-1:0] x,
  input  logic [GW-1:0] ga,
  input  logic [GW-1:0] gm,
  output logic [DW-1:0] y
);
  localparam logic signed [PW-1:0] POS_LIM = PW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [PW-1:0] NEG_LIM = -PW'(64'sd1 <<< (DW - 1));

  logic [2*GW-1:0]       gprod;
  logic [GW-1:0]         g;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  rnd;

  always_comb begin
    gprod = ga * gm;
    g     = gprod[GW+15:16];
    prod  = $signed(x) * $signed({1'b0, g});
    rnd   = (prod + PW'(32768)) >>> 16;
    if (rnd > POS_LIM)      y = POS_LIM[DW-1:0];
    else if (rnd < NEG_LIM) y = NEG_LIM[DW-1:0];
    else                    y = rnd[DW-1:0];
  end
endmodule

// File: rtl/soft_atten.sv
module soft_atten #(
  parameter int DW       = 24,
  parameter int CW       = 8,
  parameter int LVL_MAX  = 7424,
  parameter int SEG      = 350,
  parameter int MUTE_LEN = 1024,
  localparam int LW = $clog2(LVL_MAX + 1),
  localparam int MW = $clog2(MUTE_LEN + 1),
  localparam int GW = att_pkg::GAIN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn,
  input  logic          soft_rst,
  input  logic          att_wr,
  input  logic [CW-1:0] att_code,
  input  logic          smute,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          step;
  logic [LW-1:0] lvl_w;
  logic [MW-1:0] mlev_w;
  logic [GW-1:0] ga_w, gm_w;
  logic [DW-1:0] scaled_w;
  logic          ov_q;
  logic [DW-1:0] od_q;

  assign in_ready = !pwr_dn && (!ov_q || out_ready);
  assign step     = in_valid && in_ready;

  att_level_ramp #(.CW(CW), .LVL_MAX(LVL_MAX), .SEG(SEG)) u_lvl (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .soft_rst(soft_rst),
    .att_wr(att_wr), .att_code(att_code), .step(step),
    .lvl(lvl_w), .gain(ga_w)
  );

  mute_ramp #(.MUTE_LEN(MUTE_LEN)) u_mute (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .smute(smute), .step(step),
    .mlev(mlev_w), .gain(gm_w)
  );

  gain_scaler #(.DW(DW)) u_scl (
    .x(in_data), .ga(ga_w), .gm(gm_w), .y(scaled_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else if (pwr_dn) begin
      ov_q <= 1'b0;
    end else if (step) begin
      ov_q <= 1'b1;
      od_q <= scaled_w;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/soft_atten_chk.sv
module soft_atten_chk #(
  parameter int DW       = 24,
  parameter int LVL_MAX  = 7424,
  parameter int MUTE_LEN = 1024,
  localparam int LW = $clog2(LVL_MAX + 1),
  localparam int MW = $clog2(MUTE_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_dn,
  input logic          soft_rst,
  input logic          smute,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [LW-1:0] lvl,
  input logic [MW-1:0] mlev
);
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && !soft_rst) |=> ((lvl == $past(lvl)) || (lvl == $past(lvl) + 1'b1) || (lvl + 1'b1 == $past(lvl))));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && !soft_rst && !(in_valid && in_ready)) |=> $stable(lvl));

  a_r3_mute_step: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn |=> ((mlev == $past(mlev)) || (mlev == $past(mlev) + 1'b1) || (mlev + 1'b1 == $past(mlev))));

  a_r3_mute_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && smute && in_valid && in_ready) |=> (mlev <= $past(mlev)));

  a_r6_pdn_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!out_valid && lvl == LW'(LVL_MAX) && mlev == MW'(MUTE_LEN)));

  a_r6_pdn_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !in_ready);

  a_r7_srst_full: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !pwr_dn) |=> (lvl == LW'(LVL_MAX)));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !pwr_dn) |=> (out_valid && $stable(out_data)));
endmodule

bind soft_atten soft_atten_chk #(.DW(DW), .LVL_MAX(LVL_MAX), .MUTE_LEN(MUTE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .soft_rst(soft_rst), .smute(smute),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .lvl(lvl_w), .mlev(mlev_w)
);

// File: tb/soft_atten_tb.sv
`timescale 1ns/1ps
module soft_atten_tb;
  localparam int LMAX = 7424;
  localparam int SEGL = 350;
  localparam int ML   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_dn = 1'b0, soft_rst = 1'b0, att_wr = 1'b0, smute = 1'b0;
  logic [7:0] att_code = 8'hFF;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [23:0] in_data = '0;
  logic in_ready, out_valid;
  logic [23:0] out_data;

  always #2.5 clk = ~clk;

  soft_atten #(.MUTE_LEN(ML)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .soft_rst(soft_rst),
    .att_wr(att_wr), .att_code(att_code), .smute(smute),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R10";
  int m_code = 255, m_lvl = LMAX, m_mute = ML;
  int exp_q[$];
  string tag_q[$];

  task automatic check(string tag, longint act, longint expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic longint gain_a(int l);
    longint k, s, f, b;
    if (l == 0) return 0;
    k = LMAX - l; s = k / SEGL; f = k % SEGL;
    if (s > 16) return 0;
    b = 65536 - (f * 32768) / SEGL;
    return b >> s;
  endfunction

  function automatic int expect_out(int x, int l, int m);
    longint gm, g, r;
    gm = (longint'(m) * 65536) / ML;
    g  = (gain_a(l) * gm) >> 16;
    r  = (longint'(x) * g + 32768) >>> 16;
    if (r > 8388607)  r = 8388607;
    if (r < -8388608) r = -8388608;
    return int'(r);
  endfunction

  task automatic cyc(input bit iv, input logic [23:0] d, input bit ordy,
                     input bit aw, input logic [7:0] ac, input bit sm,
                     input bit sr, input bit pd);
    bit acc;
    int tgt;
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy; att_wr = aw;
    att_code = ac; smute = sm; soft_rst = sr; pwr_dn = pd;
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R8 unexpected output", 1, 0);
      else check(tag_q.pop_front(), longint'($signed(out_data)), exp_q.pop_front());
    end
    acc = in_valid && in_ready;
    if (pd) begin
      m_code = 255; m_lvl = LMAX; m_mute = ML;
      exp_q.delete(); tag_q.delete();
    end else begin
      if (acc) begin
        exp_q.push_back(expect_out(int'($signed(d)), m_lvl, m_mute));
        tag_q.push_back(cur_tag);
      end
      tgt = (m_code * LMAX) / 255;
      if (sr) m_lvl = LMAX;
      else if (acc) begin
        if (m_lvl < tgt) m_lvl++;
        else if (m_lvl > tgt) m_lvl--;
      end
      if (acc) begin
        if (sm && m_mute > 0) m_mute--;
        else if (!sm && m_mute < ML) m_mute++;
      end
      if (aw) m_code = int'(ac);
    end
  endtask

  task automatic feed(int n, logic [7:0] code_now, bit sm);
    for (int i = 0; i < n; i++)
      cyc(1'b1, 24'($urandom), 1'b1, 1'b0, code_now, sm, 1'b0, 1'b0);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, 1'b0, 8'h00, smute, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10 out_valid after reset", out_valid, 0);
    check("R10 in_ready after reset", in_ready, 1);

    // R5 unity passthrough and R10 default code
    cur_tag = "R5 unity";
    cyc(1'b1, 24'h123456, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 24'h800000, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0);
    flush();

    // R8 random back-pressure at unity
    cur_tag = "R8 handshake";
    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 3) != 0, 24'($urandom), $urandom_range(0, 2) != 0,
          1'b0, 8'hFF, 1'b0, 1'b0, 1'b0);
    flush();

    // R2 R4 full sweep to mute
    cur_tag = "R2 R4 sweep down";
    cyc(1'b0, '0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    feed(LMAX, 8'h00, 1'b0);
    cur_tag = "R1 mute code";
    cyc(1'b1, 24'h7FFFFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 24'h800000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    flush();

    // R2 sweep back up, then R1 intermediate code
    cur_tag = "R2 R4 sweep up";
    cyc(1'b0, '0, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    feed(LMAX + 4, 8'hFF, 1'b0);
    cur_tag = "R1 code 80h";
    cyc(1'b0, '0, 1'b1, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0);
    feed(3800, 8'h80, 1'b0);
    flush();

    // R3 full soft mute, release, mid-ramp cancel; R9 level untouched
    cur_tag = "R3 R9 mute";
    feed(ML + 5, 8'h80, 1'b1);
    feed(ML + 5, 8'h80, 1'b0);
    feed(20, 8'h80, 1'b1);
    feed(30, 8'h80, 1'b0);
    flush();

    // R7 soft reset during a ramp
    cur_tag = "R7 soft reset";
    cyc(1'b0, '0, 1'b1, 1'b1, 8'h40, 1'b0, 1'b0, 1'b0);
    feed(500, 8'h40, 1'b0);
    for (int i = 0; i < 4; i++)
      cyc(1'b1, 24'($urandom), 1'b1, 1'b0, 8'h40, 1'b0, 1'b1, 1'b0);
    feed(300, 8'h40, 1'b0);
    flush();

    // R6 power-down
    cur_tag = "R6 power-down";
    feed(10, 8'h40, 1'b1);
    cyc(1'b1, 24'h111111, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1);
    @(negedge clk); #1;
    check("R6 in_ready during power-down", in_ready, 0);
    check("R6 out_valid during power-down", out_valid, 0);
    cyc(1'b0, '0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 24'h3A5A5A, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    flush();

    // R9 random mix of everything
    cur_tag = "R9 random mix";
    begin
      bit sm_s = 0;
      for (int i = 0; i < 20000; i++) begin
        bit aw, sr, pd;
        if ($urandom_range(0, 99) == 0) sm_s = ~sm_s;
        aw = ($urandom_range(0, 49) == 0);
        sr = ($urandom_range(0, 299) == 0);
        pd = ($urandom_range(0, 499) == 0);
        cyc($urandom_range(0, 3) != 0, 24'($urandom), $urandom_range(0, 3) != 0,
            aw, 8'($urandom), sm_s, sr, pd);
      end
    end
    flush();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule